// File: doc/BRIEF.md
# Two-Phase Mesh Barrier Synchronizer

This block sits in every node of a two-dimensional mesh. It lets the nodes agree that an algorithmic time step is over and move to the next one together, with no global clock. Each node passes barrier tokens only to the nodes directly beside it, over a fixed spanning tree. Within a row, the tree runs toward column 0. Along column 0, it runs toward row 0. The node at column 0, row 0 is the root.

In the first phase, called flush, the tokens travel up the tree. A node sends its flush token only after three things are true: its local work for the step is finished, every child has reported flush, and its own outgoing spike queue is empty. Because of this, once the root holds the flush from the whole mesh, no spike can still be in flight. In the second phase, the root sends an advance token back down the same tree. Each node then increments its step counter, gives a one-clock advance pulse and resumes work. A host can ask the root for a hold window. The root opens it before the advance phase, and management traffic may run during it until a release arrives.

Each node is placed by parameters: mesh size (`NCOLS`, `NROWS`) and its own column and row (`COL`, `ROW`).

Top module: `mesh_barrier_node`

## Requirements
- R1: After reset the step count is 0, `step_advance` is low, `hold_active` is low, and no output token is valid.
- R2: A node starts its barrier only after two conditions hold. First, a `work_done` pulse must have been latched in the running phase. Second, a flush token must have arrived from every child port. If a child has not reported, nothing leaves the node.
- R3: The barrier also waits for `spikes_idle` to be high. While it is low, the flush token (or, at the root, the advance phase) is held back.
- R4: Bit index per direction: W=0, E=1, S=2, N=3. The parent is W when COL>0, S when COL=0 and ROW>0, and there is none at the root. The children are E when COL<NCOLS-1, and N when COL=0 and ROW<NROWS-1. Token kind 0 is flush and kind 1 is advance.
- R5: Every port uses a valid/ready handshake, and a token passes on a clock edge where both are high. An output token stays valid, with the same kind, until it is taken.
- R6: A non-root node that has sent its flush waits for an advance token on its parent port. An advance token offered on a child port is refused (ready low). A flush token offered on the parent port is also refused.
- R7: In the advance phase the node offers an advance token on each child port. Each child may accept on a different cycle. The step count rises by one on the edge where the last child accepts. A node with no children does this one cycle after it starts the phase.
- R8: `step_advance` is high for exactly one clock, the cycle after the step count changes. The step count wraps modulo 2^STEP_W.
- R9: At the root, a `hold_req` pulse that arrives before the advance phase starts makes the root enter a hold window once the flush is complete. During the window `hold_active` is high and no token is offered. A `hold_release` pulse ends the window and starts the advance phase.
- R10: A `work_done` pulse that arrives outside the running phase is ignored and does not count toward the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| work_done | input | 1 | Pulse: local compartment work for the step is finished |
| spikes_idle | input | 1 | Local outgoing spike queue is empty |
| hold_req | input | 1 | Request for a hold window before advance (used at root) |
| hold_release | input | 1 | Ends the hold window (used at root) |
| hold_active | output | 1 | Hold window open |
| tok_in_valid | input | 4 | Incoming token valid, per direction |
| tok_in_kind | input | 4 | Incoming token kind, per direction |
| tok_in_ready | output | 4 | Incoming token accepted, per direction |
| tok_out_valid | output | 4 | Outgoing token valid, per direction |
| tok_out_kind | output | 4 | Outgoing token kind, per direction |
| tok_out_ready | input | 4 | Neighbour accepts outgoing token, per direction |
| step_count | output | STEP_W | Current time step |
| step_advance | output | 1 | One-clock pulse on step advance |

## Verification
The in-module properties are checked on every cycle. They cover:
- the barrier leaves the running phase only with the spike queue idle and the work latched;
- an offered token is never withdrawn;
- a non-root node advances only after an advance token on its parent port;
- the step count moves only together with a single-cycle pulse;
- the hold window stays silent.

Other behaviour needs the bench's scenarios. These are tree direction selection, refusal of wrongly placed tokens, acknowledgement in either child order, the ignored early `work_done`, and counter wrap. The bench runs a root node and a column-0 interior node with a narrow counter and plays the neighbours around both.

// File: rtl/mesh_barrier_node.sv
`timescale 1ns/1ps
module mesh_barrier_node #(
  parameter int NCOLS  = 4,
  parameter int NROWS  = 4,
  parameter int COL    = 0,
  parameter int ROW    = 0,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              work_done,
  input  logic              spikes_idle,
  input  logic              hold_req,
  input  logic              hold_release,
  output logic              hold_active,
  input  logic [3:0]        tok_in_valid,
  input  logic [3:0]        tok_in_kind,
  output logic [3:0]        tok_in_ready,
  output logic [3:0]        tok_out_valid,
  output logic [3:0]        tok_out_kind,
  input  logic [3:0]        tok_out_ready,
  output logic [STEP_W-1:0] step_count,
  output logic              step_advance
);
  localparam bit IS_ROOT = (COL == 0) && (ROW == 0);
  localparam bit HAS_E   = (COL < NCOLS - 1);
  localparam bit HAS_N   = (COL == 0) && (ROW < NROWS - 1);
  localparam logic [3:0] KIDS   = {HAS_N, 1'b0, HAS_E, 1'b0};
  localparam logic [3:0] UPLINK = IS_ROOT ? 4'b0000 : ((COL > 0) ? 4'b0001 : 4'b0100);

  typedef enum logic [2:0] {RUN, UP, WAIT_ADV, HOLD, DOWN} phase_t;

  phase_t            st;
  logic              work_seen, hold_pend, adv_q;
  logic [3:0]        kin, kout;
  logic [STEP_W-1:0] step_q;
  logic [3:0]        in_take, out_take;
  logic              gathered, down_done;

  assign tok_in_ready  = (KIDS & ~kin & ~tok_in_kind) | (UPLINK & tok_in_kind & {4{st == WAIT_ADV}});
  assign in_take       = tok_in_valid & tok_in_ready;
  assign tok_out_valid = ({4{st == UP}} & UPLINK) | ({4{st == DOWN}} & KIDS & ~kout);
  assign tok_out_kind  = {4{st == DOWN}};
  assign out_take      = tok_out_valid & tok_out_ready;
  assign gathered      = work_seen && ((kin & KIDS) == KIDS) && spikes_idle;
  assign down_done     = (((kout | out_take) & KIDS) == KIDS);
  assign hold_active   = (st == HOLD);
  assign step_count    = step_q;
  assign step_advance  = adv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= RUN;
      work_seen <= 1'b0;
      hold_pend <= 1'b0;
      adv_q     <= 1'b0;
      kin       <= 4'b0;
      kout      <= 4'b0;
      step_q    <= '0;
    end else begin
      adv_q <= 1'b0;
      kin   <= kin | (in_take & KIDS);
      if (st == RUN && work_done) work_seen <= 1'b1;
      if (IS_ROOT && hold_req) hold_pend <= 1'b1;
      case (st)
        RUN: if (gathered) begin
          kin       <= 4'b0;
          work_seen <= 1'b0;
          if (!IS_ROOT) st <= UP;
          else if (hold_pend || hold_req) begin
            st        <= HOLD;
            hold_pend <= 1'b0;
          end else st <= DOWN;
        end
        UP:       if (|out_take) st <= WAIT_ADV;
        WAIT_ADV: if (|(in_take & UPLINK)) st <= DOWN;
        HOLD:     if (hold_release) st <= DOWN;
        DOWN: begin
          kout <= kout | (out_take & KIDS);
          if (down_done) begin
            kout   <= 4'b0;
            st     <= RUN;
            step_q <= step_q + 1'b1;
            adv_q  <= 1'b1;
          end
        end
        default: st <= RUN;
      endcase
    end
  end

  p_leave_when_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == RUN && st != RUN) |-> $past(spikes_idle && work_seen));
  p_offer_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((tok_out_valid & ~tok_out_ready) != 4'b0) |=>
      ((tok_out_valid & $past(tok_out_valid & ~tok_out_ready)) == $past(tok_out_valid & ~tok_out_ready)));
  p_kind_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((tok_out_valid & ~tok_out_ready) != 4'b0) |=>
      ((tok_out_kind & $past(tok_out_valid & ~tok_out_ready)) == ($past(tok_out_kind) & $past(tok_out_valid & ~tok_out_ready))));
  p_parent_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DOWN && $past(st) == WAIT_ADV) |-> $past(|(tok_in_valid & UPLINK & tok_in_kind)));
  p_step_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_advance |-> (step_count == STEP_W'($past(step_count) + 1'b1)));
  p_step_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_advance |-> $stable(step_count));
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_advance |=> !step_advance);
  p_hold_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (tok_out_valid == 4'b0));
endmodule

// File: tb/tb_mesh_barrier_node.sv
`timescale 1ns/1ps
module tb_mesh_barrier_node;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] in_v [2];
  logic [3:0] in_k [2];
  logic [3:0] in_r [2];
  logic [3:0] out_v [2];
  logic [3:0] out_k [2];
  logic [3:0] out_r [2];
  logic       work [2];
  logic       idle [2];
  logic       adv  [2];
  logic       hreq, hrel, hact0, hact1;
  logic [15:0] step0;
  logic [2:0]  step1;

  int checks = 0, fails = 0;
  int exp_step [2];
  bit exp_adv  [2];

  mesh_barrier_node #(.NCOLS(2), .NROWS(2), .COL(0), .ROW(0), .STEP_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .work_done(work[0]), .spikes_idle(idle[0]),
    .hold_req(hreq), .hold_release(hrel), .hold_active(hact0),
    .tok_in_valid(in_v[0]), .tok_in_kind(in_k[0]), .tok_in_ready(in_r[0]),
    .tok_out_valid(out_v[0]), .tok_out_kind(out_k[0]), .tok_out_ready(out_r[0]),
    .step_count(step0), .step_advance(adv[0]));

  mesh_barrier_node #(.NCOLS(2), .NROWS(2), .COL(0), .ROW(1), .STEP_W(3)) dut_mid (
    .clk(clk), .rst_n(rst_n), .work_done(work[1]), .spikes_idle(idle[1]),
    .hold_req(1'b0), .hold_release(1'b0), .hold_active(hact1),
    .tok_in_valid(in_v[1]), .tok_in_kind(in_k[1]), .tok_in_ready(in_r[1]),
    .tok_out_valid(out_v[1]), .tok_out_kind(out_k[1]), .tok_out_ready(out_r[1]),
    .step_count(step1), .step_advance(adv[1]));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(step0 == 16'(exp_step[0]), "R7 root step", step0, exp_step[0] & 16'hffff);
    chk(adv[0] == exp_adv[0], "R8 root pulse", adv[0], exp_adv[0]);
    chk(step1 == 3'(exp_step[1]), "R8 mid step wrap", step1, exp_step[1] & 7);
    chk(adv[1] == exp_adv[1], "R8 mid pulse", adv[1], exp_adv[1]);
  end

  task automatic pulse_work(int i);
    @(negedge clk); work[i] = 1'b1;
    @(negedge clk); work[i] = 1'b0;
  endtask

  task automatic send_in(int i, int d, bit k, string req);
    int n = 0;
    @(negedge clk); in_v[i][d] = 1'b1; in_k[i][d] = k; #1;
    while (!in_r[i][d] && n < 40) begin @(negedge clk); #1; n++; end
    chk(in_r[i][d] == 1'b1, req, in_r[i][d], 1);
    @(posedge clk);
    @(negedge clk); in_v[i][d] = 1'b0; in_k[i][d] = 1'b0;
  endtask

  task automatic refuse(int i, int d, bit k, string req);
    @(negedge clk); in_v[i][d] = 1'b1; in_k[i][d] = k;
    for (int c = 0; c < 3; c++) begin
      #1; chk(in_r[i][d] == 1'b0, req, in_r[i][d], 0);
      @(negedge clk);
    end
    in_v[i][d] = 1'b0; in_k[i][d] = 1'b0;
  endtask

  task automatic take_out(int i, int d, bit k, bit last, string req);
    int n = 0;
    @(negedge clk);
    while (!out_v[i][d] && n < 40) begin @(negedge clk); n++; end
    chk(out_v[i][d] == 1'b1, req, out_v[i][d], 1);
    chk(out_k[i][d] == k, req, out_k[i][d], k);
    out_r[i][d] = 1'b1;
    @(posedge clk);
    if (last) begin exp_step[i]++; exp_adv[i] = 1'b1; end
    @(negedge clk); out_r[i][d] = 1'b0;
    if (last) begin @(posedge clk); exp_adv[i] = 1'b0; end
  endtask

  task automatic quiet(int i, int n, string req);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); chk(out_v[i] == 4'b0, req, out_v[i], 0);
    end
  endtask

  task automatic mid_round();
    pulse_work(1);
    send_in(1, 1, 1'b0, "R2 mid child flush");
    take_out(1, 2, 1'b0, 1'b0, "R4 mid flush up on S");
    send_in(1, 2, 1'b1, "R6 mid parent advance");
    take_out(1, 1, 1'b1, 1'b1, "R7 mid advance to E");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      in_v[i] = 0; in_k[i] = 0; out_r[i] = 0; work[i] = 0; idle[i] = 1;
      exp_step[i] = 0; exp_adv[i] = 0;
    end
    hreq = 0; hrel = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_v[0] == 0 && out_v[1] == 0, "R1 no tokens after reset", out_v[0], 0);
    chk(step0 == 0 && step1 == 0, "R1 step zero", step0, 0);
    chk(hact0 == 0 && adv[0] == 0, "R1 hold and pulse low", hact0, 0);
    rst_n = 1'b1;

    // Root: children E and N, spikes busy holds the barrier
    idle[0] = 1'b0;
    pulse_work(0);
    send_in(0, 1, 1'b0, "R2 root flush from E");
    quiet(0, 3, "R2 root waits for N child");
    send_in(0, 3, 1'b0, "R2 root flush from N");
    quiet(0, 4, "R3 spikes busy holds barrier");
    idle[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(out_v[0] == 4'b1010, "R4 root children E and N", out_v[0], 4'b1010);
    chk(out_k[0][1] && out_k[0][3], "R4 advance kind", out_k[0], 4'b1111);
    take_out(0, 1, 1'b1, 1'b0, "R7 root advance E");
    take_out(0, 3, 1'b1, 1'b1, "R7 root advance N last");

    // Root: other ack order, offers held while unacked
    pulse_work(0);
    send_in(0, 3, 1'b0, "R2 root flush N first");
    send_in(0, 1, 1'b0, "R2 root flush E");
    @(negedge clk); @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); chk(out_v[0] == 4'b1010, "R5 offers held", out_v[0], 4'b1010);
    end
    take_out(0, 3, 1'b1, 1'b0, "R7 root N first");
    @(negedge clk);
    chk(out_v[0] == 4'b0010, "R7 E still pending", out_v[0], 4'b0010);
    take_out(0, 1, 1'b1, 1'b1, "R7 root E last");

    // Root: hold window
    @(negedge clk); hreq = 1'b1; @(negedge clk); hreq = 1'b0;
    pulse_work(0);
    send_in(0, 1, 1'b0, "R2 flush E before hold");
    send_in(0, 3, 1'b0, "R2 flush N before hold");
    @(negedge clk); @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(hact0 == 1'b1, "R9 hold active", hact0, 1);
      chk(out_v[0] == 4'b0, "R9 no tokens during hold", out_v[0], 0);
    end
    hrel = 1'b1; @(negedge clk); hrel = 1'b0;
    chk(hact0 == 1'b0, "R9 hold released", hact0, 0);
    take_out(0, 1, 1'b1, 1'b0, "R9 advance after release E");
    take_out(0, 3, 1'b1, 1'b1, "R9 advance after release N");

    // Mid node (column 0, row 1): parent S, child E
    pulse_work(1);
    send_in(1, 1, 1'b0, "R2 mid child flush");
    @(negedge clk); @(negedge clk);
    chk(out_v[1] == 4'b0100, "R4 mid parent is S", out_v[1], 4'b0100);
    take_out(1, 2, 1'b0, 1'b0, "R4 mid flush up");
    quiet(1, 3, "R6 mid waits for parent");
    refuse(1, 1, 1'b1, "R6 advance on child port refused");
    refuse(1, 2, 1'b0, "R6 flush on parent port refused");
    quiet(1, 2, "R6 still waiting after refusals");
    send_in(1, 2, 1'b1, "R6 mid parent advance");
    take_out(1, 1, 1'b1, 1'b1, "R7 mid advance to E");

    // Early work_done ignored
    pulse_work(1);
    send_in(1, 1, 1'b0, "R2 mid child flush");
    take_out(1, 2, 1'b0, 1'b0, "R4 mid flush up");
    pulse_work(1);
    send_in(1, 2, 1'b1, "R6 mid parent advance");
    take_out(1, 1, 1'b1, 1'b1, "R7 mid advance to E");
    send_in(1, 1, 1'b0, "R10 child flush");
    quiet(1, 4, "R10 early work_done ignored");
    pulse_work(1);
    take_out(1, 2, 1'b0, 1'b0, "R10 flush after fresh work_done");
    send_in(1, 2, 1'b1, "R6 mid parent advance");
    take_out(1, 1, 1'b1, 1'b1, "R7 mid advance to E");

    // Wrap of the narrow counter
    while (exp_step[1] < 8) mid_round();
    @(negedge clk);
    chk(step1 == 3'd0, "R8 counter wrapped to zero", step1, 0);
    mid_round();
    @(negedge clk);
    chk(step1 == 3'd1, "R8 counter after wrap", step1, 1);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule